// File: doc/BRIEF.md
# PLL Clock Source Switch Sequencer

This block decides whether the system clock comes from the external reference input or from the PLL output. Software turns the PLL on with an enable bit and then asks for the PLL clock with a separate select bit. It also programs a 5-bit multiplier field M and a 3-bit divider field N. The synthesizer produces external × (M+1)/(N+1). With the reset presets M=24 and N=0, an 11.52 MHz reference gives 288 MHz. The block drives the enable and the M/N fields to the PLL. It watches the PLL's lock output and an external-clock-present flag, and it drives a registered select for a glitch-free clock multiplexer downstream.

The block holds the external clock until the PLL reports lock. It drops back to the external clock as soon as lock, the reference, the enable or the select goes away. A lock-wait counter measures time in reference-clock cycles. Its default length is 2880 cycles, which is 250 µs at 11.52 MHz. If lock has not arrived by then, the counter raises a sticky error flag. A status register shows which clock is active, so software can poll for the end of a switch. The whole block runs on the reference clock.

Top module: `pllsw_top`

## Requirements
- R1: After reset, sel_pll and pll_en are 0, pll_m is M_RST (24), pll_n is N_RST (0), the control register reads 0 and the lock error flag is 0.
- R2: A write to address 0 stores enable in bit 0 and select in bit 1. A write to address 1 stores M in bits 4:0 and N in bits 7:5. Both registers read back what was written, and pll_en, pll_m and pll_n show the stored values from the cycle after the write.
- R3: sel_pll becomes 1 right after the first clock edge at which the stored enable and select bits, pll_lock and ext_clk_ok are all 1. Because of this, sel_pll rises one cycle after the control write that completes that condition.
- R4: While pll_lock is 0, sel_pll stays 0 regardless of the enable and select bits.
- R5: While sel_pll is 1, sel_pll returns to 0 right after the first clock edge at which any of the following is 0: pll_lock, ext_clk_ok, the stored enable bit, the stored select bit.
- R6: The lock error flag sets right after the LOCK_LIMIT-th consecutive clock edge with the stored enable at 1 and pll_lock at 0. It does not set earlier. The count starts over whenever lock is seen or the enable is 0, and it sets the flag only once per waiting period.
- R7: The lock error flag is sticky. Writing to address 2 with bit 1 set clears it, and writing with bit 1 at 0 leaves it unchanged. If a clear and an expiry fall on the same edge, the flag stays set.
- R8: Address 2 reads sel_pll in bit 0, the lock error flag in bit 1 and pll_lock in bit 2, with the other bits 0. Address 3 reads 0.
- R9: While ext_clk_ok is 0, sel_pll never rises, even with enable, select and lock all at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External reference clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on reg_addr |
| pll_lock | input | 1 | Lock indication from the PLL |
| ext_clk_ok | input | 1 | External reference clock present |
| pll_en | output | 1 | PLL power enable |
| pll_m | output | 5 | Multiplier field M to the PLL |
| pll_n | output | 3 | Divider field N to the PLL |
| sel_pll | output | 1 | Clock multiplexer select, 1 selects the PLL output |

## Verification
Two events can fall on the same clock edge: the lock-wait counter expiring and software writing the error-clear bit. The bench clears the flag and restarts a waiting period. It then issues the clear write on exactly the LOCK_LIMIT-th waiting edge and expects the flag to read 1 afterwards. A second clear, issued when no expiry is pending, must bring the flag to 0. The switch decision is also swept over all sixteen combinations of enable, select, lock and reference presence, and the fallback is provoked once for each of its four causes.

// File: rtl/pllsw_pkg.sv
package pllsw_pkg;

    parameter int M_W    = 5;
    parameter int N_W    = 3;
    parameter int DATA_W = 8;
    parameter int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_DIV  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_SEL_BIT = 1;
    localparam int STAT_CLR_BIT = 1;

    typedef enum logic [0:0] {
        SRC_EXT = 1'b0,
        SRC_PLL = 1'b1
    } src_e;

    typedef struct packed {
        logic sel;
        logic en;
    } ctrl_t;

    typedef struct packed {
        logic [N_W-1:0] n;
        logic [M_W-1:0] m;
    } div_t;

    typedef struct packed {
        logic lock;
        logic err;
        logic active;
    } stat_t;

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c);
        logic [DATA_W-1:0] v;
        v = '0;
        v[CTRL_EN_BIT]  = c.en;
        v[CTRL_SEL_BIT] = c.sel;
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] pack_stat(input stat_t s);
        logic [DATA_W-1:0] v;
        v = '0;
        v[$bits(stat_t)-1:0] = s;
        return v;
    endfunction

endpackage

// File: rtl/pllsw_regs.sv
module pllsw_regs
    import pllsw_pkg::*;
#(
    parameter logic [M_W-1:0] M_RST = 5'd24,
    parameter logic [N_W-1:0] N_RST = 3'd0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl,
    output div_t              div,
    output logic              err_clr
);

    ctrl_t ctrl_q;
    div_t  div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            div_q.m  <= M_RST;
            div_q.n  <= N_RST;
        end else if (we) begin
            if (addr == ADDR_CTRL) begin
                ctrl_q.en  <= wdata[CTRL_EN_BIT];
                ctrl_q.sel <= wdata[CTRL_SEL_BIT];
            end
            if (addr == ADDR_DIV) begin
                div_q <= div_t'(wdata[M_W+N_W-1:0]);
            end
        end
    end

    assign ctrl    = ctrl_q;
    assign div     = div_q;
    assign err_clr = we && (addr == ADDR_STAT) && wdata[STAT_CLR_BIT];

endmodule

// File: rtl/pllsw_lock_timer.sv
module pllsw_lock_timer #(
    parameter int LOCK_LIMIT = 2880
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic lock,
    input  logic clr,
    output logic err
);

    localparam int CW = $clog2(LOCK_LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LOCK_LIMIT - 1);
    localparam logic [CW-1:0] DONE = CW'(LOCK_LIMIT);

    logic [CW-1:0] cnt_q;
    logic          waiting;
    logic          expire;
    logic          err_q;

    assign waiting = en && !lock;
    assign expire  = waiting && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!waiting) begin
            cnt_q <= '0;
        end else if (expire) begin
            cnt_q <= DONE;
        end else if (cnt_q != DONE) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // expiry outranks a same-cycle clear
    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (expire) begin
            err_q <= 1'b1;
        end else if (clr) begin
            err_q <= 1'b0;
        end
    end

    assign err = err_q;

endmodule

// File: rtl/pllsw_seq.sv
module pllsw_seq
    import pllsw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic sel,
    input  logic lock,
    input  logic ext_ok,
    output logic use_pll
);

    src_e state_q, state_d;
    logic pll_good;

    assign pll_good = en && sel && lock && ext_ok;

    always_comb begin
        state_d = state_q;
        case (state_q)
            SRC_EXT: if (pll_good)  state_d = SRC_PLL;
            SRC_PLL: if (!pll_good) state_d = SRC_EXT;
            default: state_d = SRC_EXT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SRC_EXT;
        else     state_q <= state_d;
    end

    assign use_pll = (state_q == SRC_PLL);

endmodule

// File: rtl/pllsw_top.sv
module pllsw_top
    import pllsw_pkg::*;
#(
    parameter int              LOCK_LIMIT = 2880,
    parameter logic [M_W-1:0]  M_RST      = 5'd24,
    parameter logic [N_W-1:0]  N_RST      = 3'd0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              pll_lock,
    input  logic              ext_clk_ok,
    output logic              pll_en,
    output logic [M_W-1:0]    pll_m,
    output logic [N_W-1:0]    pll_n,
    output logic              sel_pll
);

    ctrl_t ctrl;
    div_t  div;
    logic  err_clr;
    logic  err_q;
    logic  use_pll;
    stat_t stat;

    pllsw_regs #(.M_RST(M_RST), .N_RST(N_RST)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .ctrl    (ctrl),
        .div     (div),
        .err_clr (err_clr)
    );

    pllsw_lock_timer #(.LOCK_LIMIT(LOCK_LIMIT)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .en   (ctrl.en),
        .lock (pll_lock),
        .clr  (err_clr),
        .err  (err_q)
    );

    pllsw_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .en      (ctrl.en),
        .sel     (ctrl.sel),
        .lock    (pll_lock),
        .ext_ok  (ext_clk_ok),
        .use_pll (use_pll)
    );

    assign stat.lock   = pll_lock;
    assign stat.err    = err_q;
    assign stat.active = use_pll;

    always_comb begin
        case (reg_addr)
            ADDR_CTRL: reg_rdata = pack_ctrl(ctrl);
            ADDR_DIV:  reg_rdata = DATA_W'(div);
            ADDR_STAT: reg_rdata = pack_stat(stat);
            default:   reg_rdata = '0;
        endcase
    end

    assign pll_en  = ctrl.en;
    assign pll_m   = div.m;
    assign pll_n   = div.n;
    assign sel_pll = use_pll;

endmodule

// File: rtl/pllsw_chk.sv
module pllsw_chk
    import pllsw_pkg::*;
#(
    parameter logic [M_W-1:0] M_RST = 5'd24,
    parameter logic [N_W-1:0] N_RST = 3'd0
) (
    input logic           clk,
    input logic           rst,
    input logic           pll_lock,
    input logic           ext_clk_ok,
    input logic           pll_en,
    input logic [M_W-1:0] pll_m,
    input logic [N_W-1:0] pll_n,
    input logic           sel_pll,
    input logic           err_q,
    input logic           err_clr
);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!sel_pll && !pll_en && pll_m == M_RST && pll_n == N_RST && !err_q));

    // R3
    rise_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sel_pll) |-> $past(pll_lock && ext_clk_ok && pll_en));

    // R5
    fallback_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_pll && !(pll_lock && ext_clk_ok && pll_en)) |=> !sel_pll);

    // R6
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_q) |-> $past(pll_en && !pll_lock));

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_q && !err_clr) |=> err_q);

endmodule

bind pllsw_top pllsw_chk #(.M_RST(M_RST), .N_RST(N_RST)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pll_lock   (pll_lock),
    .ext_clk_ok (ext_clk_ok),
    .pll_en     (pll_en),
    .pll_m      (pll_m),
    .pll_n      (pll_n),
    .sel_pll    (sel_pll),
    .err_q      (err_q),
    .err_clr    (err_clr)
);

// File: tb/sim_pllsw_top.sv
module sim_pllsw_top;

    localparam int LIM = 16;

    logic       clk = 1'b0;
    logic       rst;
    logic       reg_we;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       pll_lock;
    logic       ext_clk_ok;
    logic       pll_en;
    logic [4:0] pll_m;
    logic [2:0] pll_n;
    logic       sel_pll;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    pllsw_top #(.LOCK_LIMIT(LIM)) u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pll_lock(pll_lock),
        .ext_clk_ok(ext_clk_ok), .pll_en(pll_en), .pll_m(pll_m),
        .pll_n(pll_n), .sel_pll(sel_pll)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the falling edge after the write edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        pll_lock = 1'b0; ext_clk_ok = 1'b1;
        tick(3);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 sel_pll", {7'd0, sel_pll}, 8'd0);
        check("R1 pll_en", {7'd0, pll_en}, 8'd0);
        check("R1 pll_m", {3'd0, pll_m}, 8'd24);
        check("R1 pll_n", {5'd0, pll_n}, 8'd0);
        rd(2'd0, v); check("R1 ctrl", v, 8'h00);
        rd(2'd2, v); check("R1 err", {7'd0, v[1]}, 8'd0);
        @(negedge clk);

        // R2 divider sweep over every M/N pair
        for (int i = 0; i < 256; i++) begin
            wr(2'd1, 8'(i));
            check("R2 pll_m", {3'd0, pll_m}, 8'(i % 32));
            check("R2 pll_n", {5'd0, pll_n}, 8'(i / 32));
            rd(2'd1, v); check("R2 div readback", v, 8'(i));
            @(negedge clk);
        end
        wr(2'd0, 8'h01);
        check("R2 pll_en", {7'd0, pll_en}, 8'd1);
        rd(2'd0, v); check("R2 ctrl readback", v, 8'h01);
        @(negedge clk);
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h02);

        // R3 R4 R9 sweep of enable, select, lock, reference presence
        for (int c = 0; c < 16; c++) begin
            logic en_b, sel_b, lk_b, ok_b, exp_b;
            en_b = c[0]; sel_b = c[1]; lk_b = c[2]; ok_b = c[3];
            exp_b = en_b & sel_b & lk_b & ok_b;
            pll_lock = lk_b; ext_clk_ok = ok_b;
            wr(2'd0, {6'd0, sel_b, en_b});
            check("R3 not yet", {7'd0, sel_pll}, 8'd0);
            @(negedge clk);
            if (!lk_b)      check("R4 held ext", {7'd0, sel_pll}, 8'd0);
            else if (!ok_b) check("R9 no ref", {7'd0, sel_pll}, 8'd0);
            else            check("R3 switch", {7'd0, sel_pll}, {7'd0, exp_b});
            rd(2'd2, v);
            check("R8 status active/lock", {5'd0, v[2], 1'b0, v[0]}, {5'd0, lk_b, 1'b0, exp_b});
            @(negedge clk);
            wr(2'd0, 8'h00);
            tick(1);
            wr(2'd2, 8'h02);
        end
        rd(2'd3, v); check("R8 addr3", v, 8'h00);
        @(negedge clk);

        // R5 fallback, one cause at a time
        for (int j = 0; j < 4; j++) begin
            pll_lock = 1'b1; ext_clk_ok = 1'b1;
            wr(2'd0, 8'h03);
            @(negedge clk);
            check("R5 setup", {7'd0, sel_pll}, 8'd1);
            if (j == 0) begin pll_lock = 1'b0;   @(negedge clk); end
            if (j == 1) begin ext_clk_ok = 1'b0; @(negedge clk); end
            if (j == 2) begin wr(2'd0, 8'h02);   @(negedge clk); end
            if (j == 3) begin wr(2'd0, 8'h01);   @(negedge clk); end
            check("R5 fallback", {7'd0, sel_pll}, 8'd0);
            pll_lock = 1'b1; ext_clk_ok = 1'b1;
            wr(2'd0, 8'h00);
            tick(1);
        end

        // R6 timeout after exactly LIM waiting edges
        pll_lock = 1'b0;
        wr(2'd2, 8'h02);
        wr(2'd0, 8'h01);
        tick(LIM - 1);
        rd(2'd2, v); check("R6 not early", {7'd0, v[1]}, 8'd0);
        @(negedge clk);
        rd(2'd2, v); check("R6 expiry", {7'd0, v[1]}, 8'd1);

        // R7 write with bit1 clear has no effect, then clear with bit1
        @(negedge clk);
        wr(2'd2, 8'h00);
        rd(2'd2, v); check("R7 zero write ignored", {7'd0, v[1]}, 8'd1);
        @(negedge clk);
        wr(2'd2, 8'h02);
        rd(2'd2, v); check("R7 cleared", {7'd0, v[1]}, 8'd0);
        @(negedge clk);

        // R6 restart when lock appears mid-wait
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h02);
        wr(2'd0, 8'h01);
        tick(LIM - 3);
        pll_lock = 1'b1; @(negedge clk);
        pll_lock = 1'b0;
        tick(LIM - 1);
        rd(2'd2, v); check("R6 restart", {7'd0, v[1]}, 8'd0);
        @(negedge clk);
        rd(2'd2, v); check("R6 expiry after restart", {7'd0, v[1]}, 8'd1);
        @(negedge clk);

        // R7 clear colliding with expiry: set wins
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h02);
        wr(2'd0, 8'h01);
        tick(LIM - 1);
        wr(2'd2, 8'h02);
        rd(2'd2, v); check("R7 set beats clear", {7'd0, v[1]}, 8'd1);
        @(negedge clk);
        wr(2'd2, 8'h02);
        rd(2'd2, v); check("R7 clear after collision", {7'd0, v[1]}, 8'd0);
        @(negedge clk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule